// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Start Detection

This block sends and receives 8N1 serial frames (one low start bit, eight data bits, one high stop bit) using an external 16x oversampling tick. Each bit lasts sixteen ticks. The host drives separate transmit and receive enables and a transmit-interrupt enable. It writes transmit bytes through a strobe, reads received bytes through a strobe, and watches a set of status flags: transmit holding register empty, receive data full, overrun and framing error. A one-cycle software reset pulse returns both state machines and every flag to their reset values. A bit-order input selects LSB-first or MSB-first. Changing that input is treated as a mode change and aborts any frame in flight.

The receiver's start detector is fixed at elaboration by the parameter `START_ON_EDGE`, and the two settings differ in three cases. With level detection (0), a low line starts a frame whenever the receiver is idle and enabled. A low line seen while the receiver is disabled is also remembered, and that pending start launches reception as soon as the receiver is enabled. With edge detection (1), only a high-to-low transition seen while enabled starts a frame, and nothing is remembered while the receiver is off. In both settings the start bit is sampled again at its midpoint, which rejects short glitches.

The transmitter FSM walks TX_IDLE -> TX_START -> TX_DATA (eight bits) -> TX_STOP -> TX_IDLE. It leaves TX_IDLE when the holding register is full and transmission is enabled, and returns to TX_IDLE at once on abort or disable. The receiver FSM walks RX_IDLE -> RX_START. From RX_START it returns to RX_IDLE if the midpoint sample is high, or moves to RX_DATA (eight bits, each sampled sixteen ticks apart) -> RX_STOP -> RX_IDLE, delivering the byte or flagging a framing error. It also returns to RX_IDLE on abort or disable.

Top module: `serial_xcvr`

## Requirements
- R1: While tx_en is 0 no frame leaves (txd stays 1), and clearing tx_en mid-frame drives txd to 1 and drops the byte. While rx_en is 0 no byte is received, and clearing rx_en returns the receiver to idle.
- R2: tx_empty is 1 after reset. A wr_strobe clears it, and it returns to 1 when the transmitter takes the byte.
- R3: tx_irq is 1 exactly when tx_irq_en and tx_empty are both 1. Setting tx_irq_en while tx_empty is 1 raises tx_irq in the same cycle.
- R4: txd idles at 1. A frame is a 0 start bit, eight data bits and a 1 stop bit, each 16 baud ticks long. Data goes LSB-first when msb_first=0 and MSB-first when msb_first=1.
- R5: A received frame with stop bit 1 loads rd_data (assembled in the order set by msb_first) and sets rx_full. A rd_strobe clears rx_full, rx_overrun and rx_frame_err.
- R6: With START_ON_EDGE=0, enabling the receiver while rxd is already 0 starts reception at once (rx_busy goes to 1).
- R7: With START_ON_EDGE=0, a low rxd seen while rx_en is 0 is latched, and reception begins as soon as rx_en is set, even if rxd has returned high.
- R8: With START_ON_EDGE=1, only a falling edge of rxd while enabled starts reception. A line already low at enable, or a low seen while disabled, starts nothing.
- R9: The start bit is re-sampled on the 8th tick. If rxd is 1 there, the receiver returns to idle without setting any flag.
- R10: A sw_reset pulse returns both FSMs and any latched start to idle and sets tx_empty=1, rx_full=0, rx_overrun=0 and rx_frame_err=0.
- R11: A change of msb_first aborts any transmit or receive frame in flight. txd goes to 1, the partial data is discarded and no flag is set.
- R12: A frame that completes while rx_full is 1 sets rx_overrun, and rd_data keeps the earlier byte.
- R13: A frame whose stop bit is 0 sets rx_frame_err and leaves rx_full and rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| msb_first | input | 1 | Bit order: 0 LSB-first, 1 MSB-first; a change aborts transfers |
| sw_reset | input | 1 | One-cycle software reset pulse |
| wr_strobe | input | 1 | Writes wr_data to the transmit holding register |
| wr_data | input | DATA_W | Byte to send |
| rd_strobe | input | 1 | Read acknowledge; clears receive flags |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rd_data | output | DATA_W | Last received byte |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Received byte available |
| rx_overrun | output | 1 | A frame arrived while rx_full was set |
| rx_frame_err | output | 1 | A frame ended with a low stop bit |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_busy | output | 1 | Receiver is inside a frame |

## Verification
The bench drives two instances from the same inputs, one with each start detector, and compares each against expected values computed for its own setting. Bytes are swept in both bit orders, on transmit and on receive. The byte set includes walking ones, zero, all ones and scrambled values, so that a swapped order, a shift error or a miscounted bit gives a wrong byte. The start-condition patterns are a line held low across enable, a short low pulse while disabled, the same pulse followed by a software reset, and a short glitch while enabled. These patterns separate the two detector variants, the latched start and the midpoint recheck. Further patterns check that aborts (disable, reset, bit-order change) leave the line high and no flags set, and that overrun and a low stop bit each set only their own flag.

// File: rtl/serial_pkg.sv
package serial_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/serial_tx.sv
module serial_tx
    import serial_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              abort,
    input  logic              msb_first,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    output logic              load_ack,
    output logic              txd
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_S = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST_B = BW'(DATA_W - 1);

    tx_state_t         st, st_nx;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg, sh_nx;
    logic              last_tick;

    assign last_tick = tick && (cnt == LAST_S);

    // next-state logic
    always_comb begin
        st_nx    = st;
        load_ack = 1'b0;
        if (abort || !tx_en) begin
            st_nx = TX_IDLE;
        end else begin
            unique case (st)
                TX_IDLE:  if (have_data) begin
                              st_nx    = TX_START;
                              load_ack = 1'b1;
                          end
                TX_START: if (last_tick) st_nx = TX_DATA;
                TX_DATA:  if (last_tick && bitn == LAST_B) st_nx = TX_STOP;
                TX_STOP:  if (last_tick) st_nx = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        sh_nx = shreg;
        if (st == TX_DATA && last_tick)
            sh_nx = msb_first ? (shreg << 1) : (shreg >> 1);
    end

    // datapath and registered line output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            txd   <= 1'b1;
        end else begin
            if (st == TX_IDLE || st_nx == TX_IDLE)
                cnt <= '0;
            else if (tick)
                cnt <= (cnt == LAST_S) ? '0 : cnt + CW'(1);

            if (load_ack) begin
                shreg <= data;
                bitn  <= '0;
            end else if (st == TX_DATA && last_tick) begin
                shreg <= sh_nx;
                bitn  <= bitn + BW'(1);
            end

            unique case (st_nx)
                TX_IDLE:  txd <= 1'b1;
                TX_START: txd <= 1'b0;
                TX_DATA:  txd <= msb_first ? sh_nx[DATA_W-1] : sh_nx[0];
                TX_STOP:  txd <= 1'b1;
            endcase
        end
    end

    // R1: a disabled transmitter sits idle with the line high
    a_r1_tx_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (st == TX_IDLE) && txd);

    // R4: the start bit is driven low the cycle after a byte is taken
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> !txd);

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int OSR           = 16,
    parameter bit START_ON_EDGE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              abort,
    input  logic              msb_first,
    input  logic              rxd,
    output logic              busy,
    output logic              done,
    output logic              ferr_p,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID_S  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_S = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST_B = BW'(DATA_W - 1);

    rx_state_t         st, st_nx;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              s1, line, line_q;
    logic              pend, start_seen, start_go;
    logic              mid_tick, last_tick;

    // two-flop synchronizer plus one delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            line   <= 1'b1;
            line_q <= 1'b1;
        end else begin
            s1     <= rxd;
            line   <= s1;
            line_q <= line;
        end
    end

    assign start_seen = START_ON_EDGE ? (line_q && !line) : (pend || !line);
    assign start_go   = (st == RX_IDLE) && rx_en && !abort && start_seen;

    generate
        if (START_ON_EDGE == 1'b0) begin : g_level
            // low line while idle is remembered, even with the receiver off
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      pend <= 1'b0;
                else if (abort || start_go)      pend <= 1'b0;
                else if (st == RX_IDLE && !line) pend <= 1'b1;
            end
        end else begin : g_edge
            assign pend = 1'b0;
        end
    endgenerate

    assign mid_tick  = tick && (cnt == MID_S);
    assign last_tick = tick && (cnt == LAST_S);

    // next-state logic and event pulses
    always_comb begin
        st_nx  = st;
        done   = 1'b0;
        ferr_p = 1'b0;
        if (abort || !rx_en) begin
            st_nx = RX_IDLE;
        end else begin
            unique case (st)
                RX_IDLE:  if (start_seen) st_nx = RX_START;
                RX_START: if (mid_tick) st_nx = line ? RX_IDLE : RX_DATA;
                RX_DATA:  if (last_tick && bitn == LAST_B) st_nx = RX_STOP;
                RX_STOP:  if (last_tick) begin
                              st_nx  = RX_IDLE;
                              done   = line;
                              ferr_p = !line;
                          end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            if (st_nx != st)
                cnt <= '0;
            else if (tick)
                cnt <= (cnt == LAST_S) ? '0 : cnt + CW'(1);

            if (st == RX_START)
                bitn <= '0;
            else if (st == RX_DATA && last_tick) begin
                bitn  <= bitn + BW'(1);
                shreg <= msb_first ? {shreg[DATA_W-2:0], line}
                                   : {line, shreg[DATA_W-1:1]};
            end
        end
    end

    assign busy   = (st != RX_IDLE);
    assign byte_o = shreg;

    // R1: a disabled receiver returns to idle
    a_r1_rx_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> st == RX_IDLE);

    // R9: a high line at the start-bit midpoint sends the receiver back to idle
    a_r9_mid_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && mid_tick && line) |=> st == RX_IDLE);

    generate
        if (START_ON_EDGE == 1'b0) begin : g_lvl_chk
            // R6: level mode starts on a low line when enabled
            a_r6_level_start: assert property (@(posedge clk) disable iff (!rst_n)
                (st == RX_IDLE && rx_en && !abort && !line) |=> st == RX_START);
        end else begin : g_edge_chk
            // R8: edge mode leaves idle only after a falling edge
            a_r8_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
                (st == RX_IDLE && !(line_q && !line)) |=> st == RX_IDLE);
        end
    endgenerate

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
    parameter int DATA_W        = 8,
    parameter int OSR           = 16,
    parameter bit START_ON_EDGE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_irq_en,
    input  logic              msb_first,
    input  logic              sw_reset,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              rxd,
    output logic              txd,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_frame_err,
    output logic              tx_irq,
    output logic              rx_busy
);
    logic              mode_q, abort;
    logic [DATA_W-1:0] tdr;
    logic              load_ack, rx_done, rx_ferr_p;
    logic [DATA_W-1:0] rx_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= msb_first;
    end

    assign abort = sw_reset || (msb_first != mode_q);

    // transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdr      <= '0;
            tx_empty <= 1'b1;
        end else if (sw_reset) begin
            tx_empty <= 1'b1;
        end else begin
            if (load_ack) tx_empty <= 1'b1;
            if (wr_strobe) begin
                tdr      <= wr_data;
                tx_empty <= 1'b0;
            end
        end
    end

    // receive data register and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data      <= '0;
            rx_full      <= 1'b0;
            rx_overrun   <= 1'b0;
            rx_frame_err <= 1'b0;
        end else if (sw_reset) begin
            rx_full      <= 1'b0;
            rx_overrun   <= 1'b0;
            rx_frame_err <= 1'b0;
        end else begin
            if (rd_strobe) begin
                rx_full      <= 1'b0;
                rx_overrun   <= 1'b0;
                rx_frame_err <= 1'b0;
            end
            if (rx_done) begin
                if (rx_full && !rd_strobe) begin
                    rx_overrun <= 1'b1;
                end else begin
                    rd_data <= rx_byte;
                    rx_full <= 1'b1;
                end
            end
            if (rx_ferr_p) rx_frame_err <= 1'b1;
        end
    end

    assign tx_irq = tx_irq_en && tx_empty;

    serial_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .tx_en     (tx_en),
        .abort     (abort),
        .msb_first (msb_first),
        .have_data (!tx_empty),
        .data      (tdr),
        .load_ack  (load_ack),
        .txd       (txd)
    );

    serial_rx #(.DATA_W(DATA_W), .OSR(OSR), .START_ON_EDGE(START_ON_EDGE)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .rx_en     (rx_en),
        .abort     (abort),
        .msb_first (msb_first),
        .rxd       (rxd),
        .busy      (rx_busy),
        .done      (rx_done),
        .ferr_p    (rx_ferr_p),
        .byte_o    (rx_byte)
    );

    // R2: the empty flag only rises when the transmitter takes the byte or on reset
    a_r2_empty_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(load_ack || sw_reset));

    // R10: software reset restores every flag
    a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> tx_empty && !rx_full && !rx_overrun && !rx_frame_err);

    // R11: a bit-order change leaves both directions idle
    a_r11_mode_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (msb_first != mode_q) |=> txd && !rx_busy);

    // R12: overrun only rises while a byte is already waiting
    a_r12_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_full));

    // R13: a framing error keeps the data register untouched
    a_r13_ferr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ferr_p && !sw_reset) |=> rx_frame_err && $stable(rd_data));

endmodule

// File: tb/serial_xcvr_bench.sv
`timescale 1ns/1ps
module serial_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tcnt = 2'd0;
    logic       baud_tick;
    logic       tx_en = 0, rx_en = 0, tx_irq_en = 0, msb_first = 0;
    logic       sw_reset = 0, wr_strobe = 0, rd_strobe = 0, rxd = 1;
    logic [7:0] wr_data = 8'h00;

    logic       txd_l, txd_e, emp_l, emp_e, full_l, full_e;
    logic       ovr_l, ovr_e, fe_l, fe_e, irq_l, irq_e, busy_l, busy_e;
    logic [7:0] rdat_l, rdat_e;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign baud_tick = (tcnt == 2'd3);

    serial_xcvr #(.START_ON_EDGE(1'b0)) u_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en), .rx_en(rx_en),
        .tx_irq_en(tx_irq_en), .msb_first(msb_first), .sw_reset(sw_reset),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe), .rxd(rxd),
        .txd(txd_l), .rd_data(rdat_l), .tx_empty(emp_l), .rx_full(full_l),
        .rx_overrun(ovr_l), .rx_frame_err(fe_l), .tx_irq(irq_l), .rx_busy(busy_l));

    serial_xcvr #(.START_ON_EDGE(1'b1)) u_serial_xcvr_edge (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en), .rx_en(rx_en),
        .tx_irq_en(tx_irq_en), .msb_first(msb_first), .sw_reset(sw_reset),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe), .rxd(rxd),
        .txd(txd_e), .rd_data(rdat_e), .tx_empty(emp_e), .rx_full(full_e),
        .rx_overrun(ovr_e), .rx_frame_err(fe_e), .tx_irq(irq_e), .rx_busy(busy_e));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] b);
        wr_data = b; wr_strobe = 1; wait_clk(1); wr_strobe = 0;
    endtask

    task automatic pulse_rd();
        rd_strobe = 1; wait_clk(1); rd_strobe = 0;
    endtask

    task automatic pulse_swrst();
        sw_reset = 1; wait_clk(1); sw_reset = 0;
    endtask

    function automatic logic [7:0] pattern(input int i);
        if (i < 8) return 8'(1 << i);
        if (i == 8) return 8'h00;
        if (i == 9) return 8'hFF;
        return 8'((i * 59) ^ 8'hA5);
    endfunction

    // drive one frame on rxd; stop_len is how long the stop level is held
    task automatic send_frame(input logic [7:0] b, input logic stopv, input int stop_len);
        rxd = 0; wait_clk(64);
        for (int i = 0; i < 8; i++) begin
            rxd = msb_first ? b[7-i] : b[i];
            wait_clk(64);
        end
        rxd = stopv; wait_clk(stop_len);
        rxd = 1; wait_clk(128 - stop_len);
    endtask

    // sample a frame from txd at bit midpoints
    task automatic tx_capture(output logic [7:0] got, output int bad);
        int t = 0;
        bad = 0; got = 8'h00;
        while (txd_l !== 1'b0 && t < 3000) begin wait_clk(1); t++; end
        if (t >= 3000) bad++;
        wait_clk(32);
        if (txd_l !== 1'b0) bad++;
        if (txd_l !== txd_e) bad++;
        for (int i = 0; i < 8; i++) begin
            wait_clk(64);
            if (msb_first) got[7-i] = txd_l; else got[i] = txd_l;
            if (txd_l !== txd_e) bad++;
        end
        wait_clk(64);
        if (txd_l !== 1'b1 || txd_e !== 1'b1) bad++;
        wait_clk(40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int bad;
        wait_clk(5);
        rst_n = 1;
        wait_clk(2);

        // R2 R4 R3 reset state
        chk("R2 reset tx_empty", {emp_l, emp_e}, 3);
        chk("R4 reset txd idle high", {txd_l, txd_e}, 3);
        chk("R5 reset rx_full", {full_l, full_e}, 0);
        chk("R12 R13 reset error flags", {ovr_l, fe_l, ovr_e, fe_e}, 0);
        chk("R3 reset irq low", {irq_l, irq_e}, 0);

        // R3 interrupt request follows enable and empty flag
        tx_irq_en = 1; #1;
        chk("R3 irq at once on enable", {irq_l, irq_e}, 3);
        wait_clk(1);
        pulse_wr(8'h96);
        chk("R3 irq drops after write", {irq_l, irq_e}, 0);
        chk("R2 write clears tx_empty", {emp_l, emp_e}, 0);

        // R1 no transmission while disabled
        wait_clk(300);
        chk("R1 tx off keeps line high", {txd_l, txd_e}, 3);
        chk("R1 tx off keeps byte pending", {emp_l, emp_e}, 0);
        tx_en = 1;
        tx_capture(got, bad);
        chk("R1 R4 pending byte sent after enable", got, 8'h96);
        chk("R4 frame shape", bad, 0);
        chk("R2 tx_empty back to 1", {emp_l, emp_e}, 3);
        chk("R3 irq back with empty", {irq_l, irq_e}, 3);
        tx_irq_en = 0; #1;
        chk("R3 irq off with enable", {irq_l, irq_e}, 0);

        // R4 transmit sweep in both bit orders
        for (int m = 0; m < 2; m++) begin
            msb_first = m[0];
            wait_clk(4);
            for (int i = 0; i < 14; i++) begin
                pulse_wr(pattern(i));
                tx_capture(got, bad);
                chk($sformatf("R4 tx byte msb=%0d", m), got, pattern(i));
                chk("R4 tx frame shape", bad, 0);
            end
        end
        msb_first = 0; wait_clk(4);

        // R1 clearing tx_en mid-frame aborts
        pulse_wr(8'h00); wait_clk(150);
        tx_en = 0; wait_clk(3);
        chk("R1 tx abort line high", {txd_l, txd_e}, 3);
        chk("R1 tx abort empty", {emp_l, emp_e}, 3);
        tx_en = 1; wait_clk(200);
        chk("R1 aborted byte not resent", {txd_l, txd_e}, 3);

        // R11 bit-order change aborts transmit
        pulse_wr(8'h00); wait_clk(200);
        msb_first = 1; wait_clk(3);
        chk("R11 tx abort line high", {txd_l, txd_e}, 3);
        wait_clk(400);
        chk("R11 tx stays idle", {txd_l, txd_e, emp_l, emp_e}, 15);
        msb_first = 0; wait_clk(4);

        // R10 software reset aborts transmit
        pulse_wr(8'h00); wait_clk(150);
        pulse_swrst(); wait_clk(2);
        chk("R10 tx reset line high", {txd_l, txd_e, emp_l, emp_e}, 15);

        // R5 receive sweep in both bit orders
        rx_en = 1; wait_clk(4);
        for (int m = 0; m < 2; m++) begin
            msb_first = m[0];
            wait_clk(4);
            for (int i = 0; i < 14; i++) begin
                send_frame(pattern(i), 1'b1, 64);
                chk($sformatf("R5 rx byte level msb=%0d", m), rdat_l, pattern(i));
                chk($sformatf("R5 rx byte edge msb=%0d", m), rdat_e, pattern(i));
                chk("R5 rx_full set", {full_l, full_e, ovr_l, ovr_e, fe_l, fe_e}, 48);
                pulse_rd();
                chk("R5 read clears rx_full", {full_l, full_e}, 0);
            end
        end
        msb_first = 0; wait_clk(4);

        // R12 overrun keeps first byte
        send_frame(8'h3C, 1'b1, 64);
        send_frame(8'hC5, 1'b1, 64);
        chk("R12 overrun data kept level", rdat_l, 8'h3C);
        chk("R12 overrun data kept edge", rdat_e, 8'h3C);
        chk("R12 overrun flags", {full_l, full_e, ovr_l, ovr_e}, 15);
        pulse_rd();
        chk("R5 read clears overrun", {full_l, full_e, ovr_l, ovr_e}, 0);

        // R13 framing error
        send_frame(8'h71, 1'b0, 48);
        chk("R13 ferr set", {fe_l, fe_e}, 3);
        chk("R13 no data on ferr", {full_l, full_e, busy_l, busy_e}, 0);
        chk("R13 data unchanged", rdat_l, 8'h3C);
        pulse_rd();
        chk("R5 read clears ferr", {fe_l, fe_e}, 0);

        // R9 short glitch rejected at start midpoint
        rxd = 0; wait_clk(6);
        chk("R9 glitch starts both", {busy_l, busy_e}, 3);
        wait_clk(6); rxd = 1; wait_clk(80);
        chk("R9 glitch rejected", {busy_l, busy_e, full_l, full_e, fe_l, fe_e}, 0);

        // R11 bit-order change aborts receive
        rxd = 0; wait_clk(64); rxd = 1; wait_clk(136);
        msb_first = 1; wait_clk(3);
        chk("R11 rx abort idle", {busy_l, busy_e}, 0);
        wait_clk(600);
        chk("R11 rx no flags", {full_l, full_e, fe_l, fe_e}, 0);
        msb_first = 0; wait_clk(4);

        // R1 receive disabled
        rx_en = 0; wait_clk(2);
        send_frame(8'h5A, 1'b1, 64);
        chk("R1 rx off no byte", {full_l, full_e, busy_l, busy_e}, 0);
        pulse_swrst();

        // R7 R8 latched start: short low while disabled
        rxd = 0; wait_clk(20); rxd = 1; wait_clk(20);
        rx_en = 1; wait_clk(4);
        chk("R7 latched start begins at enable", busy_l, 1);
        chk("R8 nothing latched in edge mode", busy_e, 0);
        wait_clk(60);
        chk("R7 R9 latched start rejected midpoint", {busy_l, busy_e, full_l, full_e}, 0);

        // R10 software reset clears a latched start
        rx_en = 0; wait_clk(2);
        rxd = 0; wait_clk(20); rxd = 1; wait_clk(20);
        pulse_swrst();
        rx_en = 1; wait_clk(4);
        chk("R10 latched start cleared", {busy_l, busy_e}, 0);

        // R6 R8 enable while line already low
        rx_en = 0; wait_clk(2);
        rxd = 0; wait_clk(10);
        rx_en = 1; wait_clk(4);
        chk("R6 level starts on low line", busy_l, 1);
        chk("R8 edge waits for falling edge", busy_e, 0);
        wait_clk(6); rxd = 1; wait_clk(80);
        chk("R6 R8 both idle after release", {busy_l, busy_e, full_l, full_e}, 0);
        send_frame(8'hC3, 1'b1, 64);
        chk("R8 edge receives on next edge", rdat_e, 8'hC3);
        chk("R6 level receives next frame", rdat_l, 8'hC3);
        chk("R5 both full", {full_l, full_e}, 3);

        // R10 flags restored by software reset
        tx_en = 0; pulse_wr(8'h11);
        send_frame(8'h22, 1'b1, 64);
        chk("R10 before reset", {emp_l, emp_e, full_l, full_e, ovr_l, ovr_e}, 15);
        pulse_swrst();
        chk("R10 after reset", {emp_l, emp_e, full_l, full_e, ovr_l, ovr_e, fe_l, fe_e}, 192);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule